// File: doc/BRIEF.md
# Ping-Pong Frame Buffer SRAM Switch

This block lets a microcontroller and an on-chip video engine share two external asynchronous SRAM banks (each 256K words of 16 bits) that together form a double frame buffer. At any time one bank belongs to the microcontroller and the other to the video side. The block is the only agent wired to both memories. It decides, bank by bank, whose address, strobes and write data reach the pins, so the two masters can never fight over a memory bus.

Every request from either master is registered and appears on its bank's pins one clock later. Each SRAM access fits in one clock cycle. Read data returned by a bank is registered once more and handed back to the master that issued the read, together with a valid flag. The block never drives the data pins of a bank while that bank's output enable is active, and it never drives them in the cycle right after a read. A write that arrives directly behind a read on the same bank is therefore held back for one idle cycle.

The video side asks for an exchange of the two banks through a swap request. The swap is taken on a frame-boundary pulse, and only when the microcontroller has nothing in flight. A one-cycle done pulse confirms it. A frame of 640 x 480 pixels at 8 bits per pixel, packed two pixels per word, uses 153,600 word addresses of a bank.

Top module: `sramsw_top`

## Requirements
- R1: After reset, mcu_bank is 1 (bank 1 belongs to the microcontroller, bank 0 to video). On both banks ce_n, we_n and oe_n are 1 and dq_oe is 0. swap_done, mcu_rvalid and vid_rvalid are 0.
- R2: A microcontroller request (mcu_en=1) sampled at a clock edge appears on the pins of bank mcu_bank from that edge on, for one cycle. The pins are ce_n=0, we_n=!mcu_wr, oe_n=mcu_wr, the address, and for writes the data on dq_o. The other bank sees none of it.
- R3: A video request (vid_en=1) is forwarded the same way, one cycle later, to the bank that is not mcu_bank.
- R4: For a read cycle on a bank's pins, the value on that bank's dq_i during that cycle is returned one cycle later. It goes to the issuing master's rdata port, with that master's rvalid high for one cycle. The other master's rvalid stays 0.
- R5: A bank's dq_oe is 1 only in a write cycle of that bank (ce_n=0, we_n=0), and only then does dq_o carry the write data. In idle and read cycles dq_oe is 0.
- R6: oe_n=0 and dq_oe=1 never occur together on a bank, and dq_oe is 0 in the cycle after a cycle with oe_n=0. A write that would follow a read directly on the same bank leaves that bank idle for one cycle, with all strobes inactive, and is performed in the next cycle.
- R7: A request from the owner of a bank that arrives while a held write is being issued on that bank is not forwarded.
- R8: A swap happens at a clock edge where swap_req=1, frame_edge=1 and swap_done=0, and the microcontroller is idle: mcu_en=0 and no microcontroller cycle is on the pins or held. After that edge mcu_bank is inverted and swap_done is 1 for exactly one cycle.
- R9: Without frame_edge, or while a microcontroller access is in flight, swap_req has no effect and mcu_bank keeps its value.
- R10: After a swap, microcontroller requests go to the newly selected bank and video requests go to the other one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mcu_en | input | 1 | Microcontroller access request for this cycle |
| mcu_wr | input | 1 | 1 = write, 0 = read |
| mcu_addr | input | 18 | Microcontroller word address |
| mcu_wdata | input | 16 | Microcontroller write data |
| mcu_rdata | output | 16 | Returned read data for the microcontroller |
| mcu_rvalid | output | 1 | mcu_rdata is valid this cycle |
| vid_en | input | 1 | Video-side access request |
| vid_wr | input | 1 | 1 = write, 0 = read |
| vid_addr | input | 18 | Video-side word address |
| vid_wdata | input | 16 | Video-side write data |
| vid_rdata | output | 16 | Returned read data for the video side |
| vid_rvalid | output | 1 | vid_rdata is valid this cycle |
| swap_req | input | 1 | Level request to exchange bank roles |
| frame_edge | input | 1 | Frame-boundary pulse from the video side |
| swap_done | output | 1 | One-cycle pulse after a swap |
| mcu_bank | output | 1 | Index of the bank owned by the microcontroller |
| sram_ce_n | output | 2 | Chip enable per bank, active low |
| sram_we_n | output | 2 | Write enable per bank, active low |
| sram_oe_n | output | 2 | Output enable per bank, active low |
| sram_dq_oe | output | 2 | Per bank: 1 = block drives the data pins |
| sram_addr | output | 2x18 | Word address per bank |
| sram_dq_o | output | 2x16 | Data driven to each bank |
| sram_dq_i | input | 2x16 | Data read from each bank |

## Verification
The bench tries lone microcontroller reads and writes, lone video reads, and a simultaneous write and read from the two masters. These show whether routing follows mcu_bank and whether returned data is steered to the master that issued the read rather than to the one that owns the bank now. A read followed at once by a write, with a further request pushed into the gap, separates correct turnaround from both a bus collision and a lost or doubled access. Swap attempts are made without a frame edge, with a request on the port, and with a read still on the pins. A real swap follows. Together these separate the three blocking conditions from each other and confirm that routing reverses afterwards.

// File: rtl/sramsw_pkg.sv
package sramsw_pkg;
    parameter int unsigned AW    = 18;
    parameter int unsigned DW    = 16;
    parameter int unsigned NBANK = 2;

    typedef struct packed {
        logic          en;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } sram_req_t;
endpackage

// File: rtl/sramsw_swap_ctrl.sv
module sramsw_swap_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req_i,
    input  logic frame_edge_i,
    input  logic mcu_idle_i,
    output logic sel_o,
    output logic done_o
);
    typedef struct packed {
        logic sel;
        logic done;
    } swap_st_t;

    swap_st_t s_d, s_q;
    logic     fire;

    always_comb begin
        fire   = swap_req_i && frame_edge_i && mcu_idle_i && !s_q.done;
        s_d    = s_q;
        s_d.sel  = s_q.sel ^ fire;
        s_d.done = fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sel  <= 1'b1;
            s_q.done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_o  = s_q.sel;
    assign done_o = s_q.done;

    AST_SWAP_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (s_q.sel != $past(s_q.sel))); // R8
    AST_SWAP_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sel != $past(s_q.sel)) |-> ($past(frame_edge_i) && $past(mcu_idle_i))); // R9
endmodule

// File: rtl/sramsw_bank_port.sv
module sramsw_bank_port
    import sramsw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  sram_req_t     req_i,
    input  logic          req_mcu_i,
    output logic          ce_n_o,
    output logic          we_n_o,
    output logic          oe_n_o,
    output logic          dq_oe_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] dq_o,
    output logic          rd_fire_o,
    output logic          rd_mcu_o,
    output logic          mcu_busy_o
);
    typedef struct packed {
        logic          ce_n;
        logic          we_n;
        logic          oe_n;
        logic          dq_oe;
        logic          tag_mcu;
        logic          hold_v;
        logic          hold_mcu;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        sram_req_t     hold;
    } bank_st_t;

    bank_st_t  s_d, s_q;
    sram_req_t pick;
    logic      pick_mcu;
    logic      go;

    always_comb begin
        s_d       = s_q;
        s_d.ce_n  = 1'b1;
        s_d.we_n  = 1'b1;
        s_d.oe_n  = 1'b1;
        s_d.dq_oe = 1'b0;
        go        = 1'b0;
        pick      = req_i;
        pick_mcu  = req_mcu_i;
        if (s_q.hold_v) begin
            // issue the deferred write, drop whatever arrives now
            go         = 1'b1;
            pick       = s_q.hold;
            pick_mcu   = s_q.hold_mcu;
            s_d.hold_v = 1'b0;
        end else if (req_i.en && req_i.wr && !s_q.oe_n) begin
            // read on the pins now: idle one cycle before driving
            s_d.hold_v   = 1'b1;
            s_d.hold     = req_i;
            s_d.hold_mcu = req_mcu_i;
        end else begin
            go = req_i.en;
        end
        if (go && pick.en) begin
            s_d.ce_n    = 1'b0;
            s_d.we_n    = !pick.wr;
            s_d.oe_n    = pick.wr;
            s_d.dq_oe   = pick.wr;
            s_d.addr    = pick.addr;
            s_d.wdata   = pick.wdata;
            s_d.tag_mcu = pick_mcu;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ce_n <= 1'b1;
            s_q.we_n <= 1'b1;
            s_q.oe_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ce_n_o     = s_q.ce_n;
    assign we_n_o     = s_q.we_n;
    assign oe_n_o     = s_q.oe_n;
    assign dq_oe_o    = s_q.dq_oe;
    assign addr_o     = s_q.addr;
    assign dq_o       = s_q.wdata;
    assign rd_fire_o  = !s_q.oe_n;
    assign rd_mcu_o   = s_q.tag_mcu;
    assign mcu_busy_o = (!s_q.ce_n && s_q.tag_mcu) || (s_q.hold_v && s_q.hold_mcu);

    AST_OE_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.dq_oe && !s_q.oe_n)); // R6
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.oe_n |=> !s_q.dq_oe); // R6
    AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dq_oe |-> (!s_q.we_n && !s_q.ce_n)); // R5
endmodule

// File: rtl/sramsw_top.sv
module sramsw_top
    import sramsw_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mcu_en,
    input  logic                      mcu_wr,
    input  logic [AW-1:0]             mcu_addr,
    input  logic [DW-1:0]             mcu_wdata,
    output logic [DW-1:0]             mcu_rdata,
    output logic                      mcu_rvalid,
    input  logic                      vid_en,
    input  logic                      vid_wr,
    input  logic [AW-1:0]             vid_addr,
    input  logic [DW-1:0]             vid_wdata,
    output logic [DW-1:0]             vid_rdata,
    output logic                      vid_rvalid,
    input  logic                      swap_req,
    input  logic                      frame_edge,
    output logic                      swap_done,
    output logic                      mcu_bank,
    output logic [NBANK-1:0]          sram_ce_n,
    output logic [NBANK-1:0]          sram_we_n,
    output logic [NBANK-1:0]          sram_oe_n,
    output logic [NBANK-1:0]          sram_dq_oe,
    output logic [NBANK-1:0][AW-1:0]  sram_addr,
    output logic [NBANK-1:0][DW-1:0]  sram_dq_o,
    input  logic [NBANK-1:0][DW-1:0]  sram_dq_i
);
    typedef struct packed {
        logic [DW-1:0] mcu_rdata;
        logic          mcu_rvalid;
        logic [DW-1:0] vid_rdata;
        logic          vid_rvalid;
    } ret_st_t;

    sram_req_t        mcu_req, vid_req;
    logic [NBANK-1:0] rd_fire, rd_mcu, mcu_busy;
    logic             sel, mcu_idle;
    ret_st_t          r_d, r_q;

    assign mcu_req  = '{en: mcu_en, wr: mcu_wr, addr: mcu_addr, wdata: mcu_wdata};
    assign vid_req  = '{en: vid_en, wr: vid_wr, addr: vid_addr, wdata: vid_wdata};
    assign mcu_idle = !mcu_en && !(|mcu_busy);

    sramsw_swap_ctrl u_swap (
        .clk          (clk),
        .rst_n        (rst_n),
        .swap_req_i   (swap_req),
        .frame_edge_i (frame_edge),
        .mcu_idle_i   (mcu_idle),
        .sel_o        (sel),
        .done_o       (swap_done)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic own_mcu;
        assign own_mcu = (sel == b[0]);

        sramsw_bank_port u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (own_mcu ? mcu_req : vid_req),
            .req_mcu_i  (own_mcu),
            .ce_n_o     (sram_ce_n[b]),
            .we_n_o     (sram_we_n[b]),
            .oe_n_o     (sram_oe_n[b]),
            .dq_oe_o    (sram_dq_oe[b]),
            .addr_o     (sram_addr[b]),
            .dq_o       (sram_dq_o[b]),
            .rd_fire_o  (rd_fire[b]),
            .rd_mcu_o   (rd_mcu[b]),
            .mcu_busy_o (mcu_busy[b])
        );
    end

    always_comb begin
        r_d            = r_q;
        r_d.mcu_rvalid = 1'b0;
        r_d.vid_rvalid = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            if (rd_fire[b]) begin
                if (rd_mcu[b]) begin
                    r_d.mcu_rvalid = 1'b1;
                    r_d.mcu_rdata  = sram_dq_i[b];
                end else begin
                    r_d.vid_rvalid = 1'b1;
                    r_d.vid_rdata  = sram_dq_i[b];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mcu_rdata  = r_q.mcu_rdata;
    assign mcu_rvalid = r_q.mcu_rvalid;
    assign vid_rdata  = r_q.vid_rdata;
    assign vid_rvalid = r_q.vid_rvalid;
    assign mcu_bank   = sel;

    AST_SWAP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        swap_done |-> ($past(!mcu_en) && $past(swap_req))); // R8
    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mcu_rvalid |-> $past(|(~sram_oe_n))); // R4
endmodule

// File: tb/sim_sramsw_top.sv
module sim_sramsw_top;
    import sramsw_pkg::*;

    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mcu_en = 0, mcu_wr = 0, vid_en = 0, vid_wr = 0;
    logic [AW-1:0] mcu_addr = '0, vid_addr = '0;
    logic [DW-1:0] mcu_wdata = '0, vid_wdata = '0;
    logic [DW-1:0] mcu_rdata, vid_rdata;
    logic mcu_rvalid, vid_rvalid, swap_req = 0, frame_edge = 0, swap_done, mcu_bank;
    logic [NBANK-1:0] sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [NBANK-1:0][AW-1:0] sram_addr;
    logic [NBANK-1:0][DW-1:0] sram_dq_o, sram_dq_i;

    int checks = 0, errors = 0;
    int exp_bank = 1;

    // simple memory stand-in: returned word derives from the address
    assign sram_dq_i[0] = sram_addr[0][DW-1:0] ^ 16'h3C3C;
    assign sram_dq_i[1] = sram_addr[1][DW-1:0] ^ 16'h5A5A;

    function automatic logic [DW-1:0] key(input int b);
        return (b == 0) ? 16'h3C3C : 16'h5A5A;
    endfunction

    always #(CLK_P/2) clk = ~clk;

    sramsw_top u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 mcu_bank", mcu_bank, 1);
        chk("R1 ce_n", sram_ce_n, 2'b11);
        chk("R1 we_n", sram_we_n, 2'b11);
        chk("R1 oe_n", sram_oe_n, 2'b11);
        chk("R1 dq_oe", sram_dq_oe, 2'b00);
        chk("R1 flags", {swap_done, mcu_rvalid, vid_rvalid}, 3'b000);
    endtask

    task automatic t_mcu_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int b = exp_bank;
        mcu_en = 1; mcu_wr = 1; mcu_addr = a; mcu_wdata = d;
        @(negedge clk);
        mcu_en = 0;
        chk("R2 wr ce_n", sram_ce_n[b], 0);
        chk("R2 wr we_n/oe_n", {sram_we_n[b], sram_oe_n[b]}, 2'b01);
        chk("R2 wr addr", sram_addr[b], a);
        chk("R5 wr dq_oe", sram_dq_oe[b], 1);
        chk("R5 wr dq_o", sram_dq_o[b], d);
        chk("R2 other bank idle", sram_ce_n[1-b], 1);
        @(negedge clk);
        chk("R5 idle dq_oe", sram_dq_oe, 2'b00);
    endtask

    task automatic t_mcu_read(input logic [AW-1:0] a);
        int b = exp_bank;
        mcu_en = 1; mcu_wr = 0; mcu_addr = a;
        @(negedge clk);
        mcu_en = 0;
        chk("R2 rd strobes", {sram_ce_n[b], sram_we_n[b], sram_oe_n[b]}, 3'b010);
        chk("R2 rd addr", sram_addr[b], a);
        chk("R5 rd dq_oe", sram_dq_oe[b], 0);
        @(negedge clk);
        chk("R4 mcu rvalid", {mcu_rvalid, vid_rvalid}, 2'b10);
        chk("R4 mcu rdata", mcu_rdata, a[DW-1:0] ^ key(b));
    endtask

    task automatic t_vid_read(input logic [AW-1:0] a);
        int b = 1 - exp_bank;
        vid_en = 1; vid_wr = 0; vid_addr = a;
        @(negedge clk);
        vid_en = 0;
        chk("R3 vid rd strobes", {sram_ce_n[b], sram_we_n[b], sram_oe_n[b]}, 3'b010);
        chk("R3 vid rd addr", sram_addr[b], a);
        chk("R3 mcu bank idle", sram_ce_n[exp_bank], 1);
        @(negedge clk);
        chk("R4 vid rvalid", {mcu_rvalid, vid_rvalid}, 2'b01);
        chk("R4 vid rdata", vid_rdata, a[DW-1:0] ^ key(b));
    endtask

    task automatic t_concurrent;
        int b = exp_bank;
        mcu_en = 1; mcu_wr = 1; mcu_addr = 18'h2A5A5; mcu_wdata = 16'hBEEF;
        vid_en = 1; vid_wr = 0; vid_addr = 18'h01234;
        @(negedge clk);
        mcu_en = 0; vid_en = 0;
        chk("R2 conc mcu addr", sram_addr[b], 18'h2A5A5);
        chk("R2 conc mcu we_n", sram_we_n[b], 0);
        chk("R3 conc vid addr", sram_addr[1-b], 18'h01234);
        chk("R3 conc vid oe_n", sram_oe_n[1-b], 0);
        @(negedge clk);
        chk("R4 conc vid rvalid only", {mcu_rvalid, vid_rvalid}, 2'b01);
        chk("R4 conc vid rdata", vid_rdata, 16'h1234 ^ key(1-b));
    endtask

    task automatic t_turnaround;
        int b = exp_bank;
        mcu_en = 1; mcu_wr = 0; mcu_addr = 18'h00100;
        @(negedge clk);
        chk("R6 read on pins", sram_oe_n[b], 0);
        mcu_wr = 1; mcu_addr = 18'h00200; mcu_wdata = 16'hCAFE;
        @(negedge clk);
        chk("R6 gap strobes", {sram_ce_n[b], sram_we_n[b], sram_oe_n[b], sram_dq_oe[b]}, 4'b1110);
        chk("R4 read back before gap", mcu_rdata, 16'h0100 ^ key(b));
        mcu_wr = 0; mcu_addr = 18'h00333;
        @(negedge clk);
        mcu_en = 0;
        chk("R6 held write", {sram_ce_n[b], sram_we_n[b], sram_oe_n[b], sram_dq_oe[b]}, 4'b0011);
        chk("R6 held write addr", sram_addr[b], 18'h00200);
        chk("R6 held write data", sram_dq_o[b], 16'hCAFE);
        @(negedge clk);
        chk("R7 dropped request not issued", sram_ce_n[b], 1);
        @(negedge clk);
        chk("R7 no read return", mcu_rvalid, 0);
    endtask

    task automatic t_swap_blocked;
        // request on the port in the same cycle
        mcu_en = 1; mcu_wr = 0; mcu_addr = 18'h00010;
        swap_req = 1; frame_edge = 1;
        @(negedge clk);
        mcu_en = 0;
        chk("R9 busy port no swap", {mcu_bank, swap_done}, {exp_bank[0], 1'b0});
        // read still on the pins
        @(negedge clk);
        chk("R9 in-flight no swap", {mcu_bank, swap_done}, {exp_bank[0], 1'b0});
        frame_edge = 0;
        idle_cycles(2);
        chk("R9 no edge no swap", {mcu_bank, swap_done}, {exp_bank[0], 1'b0});
        swap_req = 0;
    endtask

    task automatic t_swap;
        swap_req = 1; frame_edge = 1;
        @(negedge clk);
        swap_req = 0; frame_edge = 0;
        exp_bank = 1 - exp_bank;
        chk("R8 bank flipped", mcu_bank, exp_bank[0]);
        chk("R8 done pulse", swap_done, 1);
        @(negedge clk);
        chk("R8 done one cycle", swap_done, 0);
        chk("R8 bank kept", mcu_bank, exp_bank[0]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        idle_cycles(2);
        t_reset();
        rst_n = 1;
        idle_cycles(1);
        t_reset();
        t_mcu_write(18'h3FFFF, 16'h1357);
        t_mcu_read(18'h25800);
        t_vid_read(18'h00000);
        t_concurrent();
        idle_cycles(1);
        t_turnaround();
        idle_cycles(1);
        t_swap_blocked();
        idle_cycles(1);
        t_swap();
        // R10: routing after the swap
        t_mcu_write(18'h12345, 16'h2468);
        t_mcu_read(18'h00ABC);
        t_vid_read(18'h0F00F);
        t_swap();
        t_mcu_read(18'h00777);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule